// File: doc/BRIEF.md
# DCO Increment Write Staging

This block sits between a 16-bit host write port and the 32-bit frequency increment registers of a bank of numerically controlled oscillators. Each channel owns one code oscillator and one carrier oscillator. The host sends an increment as two 16-bit writes. The upper half goes first and waits in a staging buffer. The lower half must be the very next write. When it arrives, the two halves are joined and handed to a pending buffer together with their destination. The destination register takes the value on the next internal transfer strobe. That strobe stands in for the slow multi-phase clock that moves host data into the oscillator domain.

A broadcast upper-half address stages one upper value that every later lower-half write can use, for any oscillator. It stays in force until the next upper-half write. One upper value can therefore reach several increment registers without being sent again. A per-channel upper half followed by anything other than its own lower half is a protocol error. The staged half is dropped and an error pulse is raised. A completed value that is not yet transferred is replaced if another one completes first, and this is reported as an overrun.

Top module: `dco_incr_stager`

## Requirements
- R1: After reset every code and carrier increment register holds RST_INCR (0 by default), nothing is pending, and proto_err and overrun are 0.
- R2: The address fields are as follows. Bit 0 selects the half (0 upper, 1 lower). Bit 1 selects the oscillator (0 code, 1 carrier). Bit 2 selects broadcast. The bits from bit 3 upward give the channel. A per-channel upper-half write followed at once by the lower-half write to the same channel and oscillator places {upper, lower} in that register on the next transfer strobe. No other register changes.
- R3: An increment register changes only at a clock edge on which xfer_stb is high. A completed value is not visible before that edge.
- R4: A lower-half write with no upper half staged has no effect on any increment register.
- R5: After a per-channel upper-half write, any next write other than the matching lower half drops the staged value and pulses proto_err for one cycle. If that write is itself a valid upper half, it becomes the new staged value.
- R6: A broadcast upper-half write (bit 2 = 1, bit 0 = 0) stays staged across lower-half writes. Each following lower-half write to any channel and oscillator completes {broadcast upper, lower} for that target. This lasts until the next upper-half write.
- R7: If a value completes while an earlier one is still pending and no strobe is present, the new value replaces the old one and overrun pulses for one cycle. The old value never reaches its register.
- R8: If a value completes on the same edge as a strobe, the strobe transfers the older pending value. The new value stays pending and no overrun is raised.
- R9: A write to a channel index at or above NUM_CH, or a broadcast lower-half write, changes no increment register and ends any staging. It raises proto_err only when a per-channel upper half was staged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write address (half, oscillator, broadcast, channel fields) |
| wr_data | input | HALF_W | Write data, one half of an increment |
| xfer_stb | input | 1 | Internal transfer strobe moving the pending value into its register |
| proto_err | output | 1 | One-cycle pulse on a broken upper/lower write pair |
| overrun | output | 1 | One-cycle pulse when a pending value is replaced before transfer |
| code_incr | output | NUM_CH*2*HALF_W | All code increment registers, channel 0 in the low bits |
| carr_incr | output | NUM_CH*2*HALF_W | All carrier increment registers, channel 0 in the low bits |

## Verification
The bench builds the block with NUM_CH = 3 and 16-bit halves, broadcast enabled. A channel field of 2 bits then leaves index 3 as an out-of-range address that can be reached. With only six increment registers, the bench checks every one of them against its computed value after each operation. It drives both per-channel and broadcast pairs to all six targets. It also covers the error sequences, the overrun and the same-edge strobe case.

// File: rtl/dco_stg_pkg.sv
package dco_stg_pkg;

   typedef enum logic [1:0] {
      STG_IDLE = 2'd0,
      STG_UNI  = 2'd1,
      STG_ALL  = 2'd2
   } stg_state_e;

   typedef enum logic {
      DCO_CODE = 1'b0,
      DCO_CARR = 1'b1
   } dco_kind_e;

   localparam int unsigned HALF_BIT  = 0;
   localparam int unsigned KIND_BIT  = 1;
   localparam int unsigned BCAST_BIT = 2;
   localparam int unsigned CH_LSB    = 3;

   function automatic int unsigned ch_bits(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/dco_stg_decode.sv
module dco_stg_decode
   import dco_stg_pkg::*;
#(
   parameter int unsigned NUM_CH   = 12,
   parameter bit          BCAST_EN = 1'b1,
   localparam int unsigned CH_W    = ch_bits(NUM_CH),
   localparam int unsigned ADDR_W  = CH_LSB + CH_W
)(
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   output logic              dec_hi_uni,
   output logic              dec_hi_all,
   output logic              dec_lo,
   output logic              dec_bad,
   output logic [CH_W-1:0]   dec_ch,
   output dco_kind_e         dec_kind
);

   logic ch_ok;
   logic uni_sel;

   assign dec_ch   = wr_addr[CH_LSB +: CH_W];
   assign dec_kind = dco_kind_e'(wr_addr[KIND_BIT]);
   assign ch_ok    = ({1'b0, dec_ch} < (CH_W+1)'(NUM_CH));
   assign uni_sel  = wr_en & ~wr_addr[BCAST_BIT] & ch_ok;

   generate
      if (BCAST_EN) begin : g_bcast
         assign dec_hi_all = wr_en & wr_addr[BCAST_BIT] & ~wr_addr[HALF_BIT];
      end else begin : g_no_bcast
         assign dec_hi_all = 1'b0;
      end
   endgenerate

   assign dec_hi_uni = uni_sel & ~wr_addr[HALF_BIT];
   assign dec_lo     = uni_sel &  wr_addr[HALF_BIT];
   assign dec_bad    = wr_en & ~(dec_hi_uni | dec_hi_all | dec_lo);

endmodule

// File: rtl/dco_stg_stage.sv
module dco_stg_stage
   import dco_stg_pkg::*;
#(
   parameter int unsigned NUM_CH  = 12,
   parameter int unsigned HALF_W  = 16,
   localparam int unsigned CH_W   = ch_bits(NUM_CH),
   localparam int unsigned FULL_W = 2 * HALF_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dec_hi_uni,
   input  logic              dec_hi_all,
   input  logic              dec_lo,
   input  logic              dec_bad,
   input  logic [CH_W-1:0]   dec_ch,
   input  dco_kind_e         dec_kind,
   input  logic [HALF_W-1:0] wr_data,
   input  logic              xfer_stb,
   output logic              pend_vld,
   output logic [FULL_W-1:0] pend_data,
   output logic [CH_W-1:0]   pend_ch,
   output dco_kind_e         pend_kind,
   output logic              proto_err,
   output logic              overrun
);

   stg_state_e        state, state_nx;
   logic [HALF_W-1:0] hi_buf;
   logic [CH_W-1:0]   uni_ch;
   dco_kind_e         uni_kind;
   logic              any_wr;
   logic              match_lo;
   logic              complete;
   logic              err_nx;

   assign any_wr   = dec_hi_uni | dec_hi_all | dec_lo | dec_bad;
   assign match_lo = dec_lo && (dec_ch == uni_ch) && (dec_kind == uni_kind);
   assign complete = ((state == STG_UNI) && match_lo) ||
                     ((state == STG_ALL) && dec_lo);
   assign err_nx   = (state == STG_UNI) && any_wr && !match_lo;

   always_comb begin
      state_nx = state;
      if (any_wr) begin
         if (dec_hi_all)
            state_nx = STG_ALL;
         else if (dec_hi_uni)
            state_nx = STG_UNI;
         else if ((state == STG_ALL) && dec_lo)
            state_nx = STG_ALL;
         else
            state_nx = STG_IDLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= STG_IDLE;
         hi_buf   <= '0;
         uni_ch   <= '0;
         uni_kind <= DCO_CODE;
      end else begin
         state <= state_nx;
         if (dec_hi_uni || dec_hi_all)
            hi_buf <= wr_data;
         if (dec_hi_uni) begin
            uni_ch   <= dec_ch;
            uni_kind <= dec_kind;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_vld  <= 1'b0;
         pend_data <= '0;
         pend_ch   <= '0;
         pend_kind <= DCO_CODE;
         proto_err <= 1'b0;
         overrun   <= 1'b0;
      end else begin
         proto_err <= err_nx;
         overrun   <= complete && pend_vld && !xfer_stb;
         if (complete) begin
            pend_vld  <= 1'b1;
            pend_data <= {hi_buf, wr_data};
            pend_ch   <= dec_ch;
            pend_kind <= dec_kind;
         end else if (xfer_stb) begin
            pend_vld  <= 1'b0;
         end
      end
   end

   // R4
   stray_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == STG_IDLE && dec_lo && !xfer_stb) |=> $stable(pend_vld) && $stable(pend_data));

   // R5
   err_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == STG_UNI && dec_bad) |=> proto_err && state == STG_IDLE);

   // R6
   all_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == STG_ALL && dec_lo) |=> state == STG_ALL && pend_vld);

   // R7
   overrun_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |-> pend_vld);

   // R8
   same_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_stb && pend_vld && complete) |=> pend_vld && !overrun);

endmodule

// File: rtl/dco_stg_bank.sv
module dco_stg_bank
   import dco_stg_pkg::*;
#(
   parameter int unsigned NUM_CH   = 12,
   parameter int unsigned HALF_W   = 16,
   parameter logic [2*HALF_W-1:0] RST_INCR = '0,
   localparam int unsigned CH_W    = ch_bits(NUM_CH),
   localparam int unsigned FULL_W  = 2 * HALF_W
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     commit,
   input  logic [FULL_W-1:0]        pend_data,
   input  logic [CH_W-1:0]          pend_ch,
   input  dco_kind_e                pend_kind,
   output logic [NUM_CH*FULL_W-1:0] code_incr,
   output logic [NUM_CH*FULL_W-1:0] carr_incr
);

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         logic hit;
         assign hit = commit && (pend_ch == CH_W'(c));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               code_incr[c*FULL_W +: FULL_W] <= RST_INCR;
               carr_incr[c*FULL_W +: FULL_W] <= RST_INCR;
            end else if (hit) begin
               if (pend_kind == DCO_CODE)
                  code_incr[c*FULL_W +: FULL_W] <= pend_data;
               else
                  carr_incr[c*FULL_W +: FULL_W] <= pend_data;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/dco_incr_stager.sv
module dco_incr_stager
   import dco_stg_pkg::*;
#(
   parameter int unsigned NUM_CH   = 12,
   parameter int unsigned HALF_W   = 16,
   parameter bit          BCAST_EN = 1'b1,
   parameter logic [2*HALF_W-1:0] RST_INCR = '0,
   localparam int unsigned CH_W    = ch_bits(NUM_CH),
   localparam int unsigned ADDR_W  = CH_LSB + CH_W,
   localparam int unsigned FULL_W  = 2 * HALF_W
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [ADDR_W-1:0]        wr_addr,
   input  logic [HALF_W-1:0]        wr_data,
   input  logic                     xfer_stb,
   output logic                     proto_err,
   output logic                     overrun,
   output logic [NUM_CH*FULL_W-1:0] code_incr,
   output logic [NUM_CH*FULL_W-1:0] carr_incr
);

   generate
      if (NUM_CH < 1) begin : g_bad_ch
         $error("NUM_CH must be at least 1");
      end
      if (HALF_W < 1) begin : g_bad_w
         $error("HALF_W must be at least 1");
      end
   endgenerate

   logic              dec_hi_uni, dec_hi_all, dec_lo, dec_bad;
   logic [CH_W-1:0]   dec_ch;
   dco_kind_e         dec_kind;
   logic              pend_vld;
   logic [FULL_W-1:0] pend_data;
   logic [CH_W-1:0]   pend_ch;
   dco_kind_e         pend_kind;

   dco_stg_decode #(.NUM_CH(NUM_CH), .BCAST_EN(BCAST_EN)) u_dec (
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .dec_hi_uni (dec_hi_uni),
      .dec_hi_all (dec_hi_all),
      .dec_lo     (dec_lo),
      .dec_bad    (dec_bad),
      .dec_ch     (dec_ch),
      .dec_kind   (dec_kind)
   );

   dco_stg_stage #(.NUM_CH(NUM_CH), .HALF_W(HALF_W)) u_stage (
      .clk        (clk),
      .rst_n      (rst_n),
      .dec_hi_uni (dec_hi_uni),
      .dec_hi_all (dec_hi_all),
      .dec_lo     (dec_lo),
      .dec_bad    (dec_bad),
      .dec_ch     (dec_ch),
      .dec_kind   (dec_kind),
      .wr_data    (wr_data),
      .xfer_stb   (xfer_stb),
      .pend_vld   (pend_vld),
      .pend_data  (pend_data),
      .pend_ch    (pend_ch),
      .pend_kind  (pend_kind),
      .proto_err  (proto_err),
      .overrun    (overrun)
   );

   dco_stg_bank #(.NUM_CH(NUM_CH), .HALF_W(HALF_W), .RST_INCR(RST_INCR)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .commit     (xfer_stb & pend_vld),
      .pend_data  (pend_data),
      .pend_ch    (pend_ch),
      .pend_kind  (pend_kind),
      .code_incr  (code_incr),
      .carr_incr  (carr_incr)
   );

   // R3
   dest_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer_stb |=> $stable(code_incr) && $stable(carr_incr));

   // R1
   reset_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !proto_err && !overrun);

endmodule

// File: tb/tb_dco_incr_stager.sv
module tb_dco_incr_stager;

   localparam int unsigned NCH = 3;
   localparam int unsigned HW  = 16;
   localparam int unsigned AW  = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [HW-1:0] wr_data = '0;
   logic          xfer_stb = 1'b0;
   logic          proto_err, overrun;
   logic [NCH*32-1:0] code_incr, carr_incr;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [31:0] ec [NCH];
   logic [31:0] ek [NCH];

   always #10 clk = ~clk;

   dco_incr_stager #(.NUM_CH(NCH), .HALF_W(HW)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .xfer_stb(xfer_stb), .proto_err(proto_err),
      .overrun(overrun), .code_incr(code_incr), .carr_incr(carr_incr)
   );

   function automatic logic [AW-1:0] adr(input int ch, input int kind, input int half);
      return AW'((ch << 3) | (kind << 1) | half);
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic chk_all(input string tag);
      for (int c = 0; c < NCH; c++) begin
         chk(tag, code_incr[c*32 +: 32], ec[c]);
         chk(tag, carr_incr[c*32 +: 32], ek[c]);
      end
   endtask

   task automatic cyc(input logic we, input logic [AW-1:0] a, input logic [HW-1:0] d,
                      input logic stb);
      wr_en = we; wr_addr = a; wr_data = d; xfer_stb = stb;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0; xfer_stb = 1'b0;
   endtask

   task automatic wr(input int ch, input int kind, input int half, input logic [HW-1:0] d);
      cyc(1'b1, adr(ch, kind, half), d, 1'b0);
   endtask

   task automatic stb();
      cyc(1'b0, '0, '0, 1'b1);
   endtask

   task automatic set_exp(input int ch, input int kind, input logic [31:0] v);
      if (kind == 0) ec[ch] = v; else ek[ch] = v;
   endtask

   initial begin
      logic [15:0] h, l, b;
      for (int c = 0; c < NCH; c++) begin ec[c] = '0; ek[c] = '0; end
      repeat (3) @(negedge clk);
      // R1 reset state
      chk_all("R1");
      chk("R1 err", {31'd0, proto_err}, 32'd0);
      chk("R1 ovr", {31'd0, overrun}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 / R3 sweep of per-channel pairs over every target
      for (int c = 0; c < NCH; c++) begin
         for (int k = 0; k < 2; k++) begin
            h = 16'h1000 + 16'(c * 16 + k);
            l = 16'hC000 ^ 16'(c * 257 + k * 3);
            wr(c, k, 0, h);
            wr(c, k, 1, l);
            chk_all("R3 before strobe");
            stb();
            set_exp(c, k, {h, l});
            chk_all("R2");
         end
      end

      // R4 stray low half
      wr(1, 0, 1, 16'hDEAD);
      stb();
      chk_all("R4");

      // R5 mismatched low after upper
      wr(0, 0, 0, 16'h7777);
      wr(1, 0, 1, 16'h8888);
      chk("R5 err pulse", {31'd0, proto_err}, 32'd1);
      stb();
      chk_all("R5 no load");
      chk("R5 err cleared", {31'd0, proto_err}, 32'd0);
      // R5 second upper replaces the first
      wr(2, 1, 0, 16'h1111);
      wr(0, 1, 0, 16'h2222);
      chk("R5 err on upper", {31'd0, proto_err}, 32'd1);
      wr(0, 1, 1, 16'h3333);
      chk("R5 no err", {31'd0, proto_err}, 32'd0);
      stb();
      set_exp(0, 1, 32'h22223333);
      chk_all("R5 restaged");

      // R6 broadcast upper reused for all targets
      b = 16'hB0B0;
      cyc(1'b1, AW'(3'b100), b, 1'b0);
      for (int c = 0; c < NCH; c++) begin
         for (int k = 0; k < 2; k++) begin
            l = 16'(16'h0A00 + c * 2 + k);
            wr(c, k, 1, l);
            stb();
            set_exp(c, k, {b, l});
            chk_all("R6 broadcast");
         end
      end
      // R6 a per-channel upper ends the broadcast
      wr(0, 0, 0, 16'h4444);
      wr(0, 0, 1, 16'h5555);
      stb();
      set_exp(0, 0, 32'h44445555);
      wr(1, 0, 1, 16'h6666);
      stb();
      chk_all("R6 ended");

      // R7 overrun
      wr(0, 0, 0, 16'hAAAA); wr(0, 0, 1, 16'h0001);
      wr(1, 0, 0, 16'hBBBB); wr(1, 0, 1, 16'h0002);
      chk("R7 ovr pulse", {31'd0, overrun}, 32'd1);
      stb();
      set_exp(1, 0, 32'hBBBB0002);
      chk_all("R7");

      // R8 completion on the strobe edge
      wr(2, 0, 0, 16'hCCCC); wr(2, 0, 1, 16'h0003);
      wr(2, 1, 0, 16'hDDDD);
      cyc(1'b1, adr(2, 1, 1), 16'h0004, 1'b1);
      set_exp(2, 0, 32'hCCCC0003);
      chk("R8 no ovr", {31'd0, overrun}, 32'd0);
      chk_all("R8 old moved");
      stb();
      set_exp(2, 1, 32'hDDDD0004);
      chk_all("R8 new moved");

      // R9 out-of-range channel and broadcast low
      wr(3, 0, 0, 16'hEEEE);
      wr(3, 0, 1, 16'hEEEE);
      chk("R9 no err idle", {31'd0, proto_err}, 32'd0);
      stb();
      chk_all("R9 range");
      wr(0, 0, 0, 16'h9999);
      cyc(1'b1, AW'(3'b101), 16'h1234, 1'b0);
      chk("R9 err", {31'd0, proto_err}, 32'd1);
      wr(0, 0, 1, 16'h5678);
      stb();
      chk_all("R9 dropped");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog act=hung exp=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule